// File: doc/BRIEF.md
# Per-Channel Signaling Change Latch

This block watches the signaling nibble of each of 32 time-division channels as the samples arrive, one channel per valid strobe. For every channel it keeps the last value it saw, and when a new sample differs from that value it raises a sticky change flag for the channel. The first sample a channel receives after reset only loads its stored value.

The sticky flags feed a single summary change flag through a per-channel enable mask. A change on a channel whose enable bit is clear still sets that channel's flag but does not touch the summary. A second, one-bit interrupt enable gates the summary flag onto a level-sensitive interrupt line.

A small register port reads the flags and masks and writes them. Flag bits are cleared by writing 1 to them. Reads have no side effects. The channel positions that carry multiframe alignment or remote alarm bits in channel-associated signaling framing are treated exactly like every other channel.

Top module: `sig_chg_latch`

## Requirements
- R1: Channel index k (0 to 31) maps to status register address k/8, bit k mod 8. The change-enable mask uses the same layout at addresses 4 to 7. The summary flag is bit 0 of address 8. The interrupt enable is bit 0 of address 9. All other addresses and bits read 0.
- R2: The first valid sample for a channel after reset only stores its 4-bit value and sets no status bit.
- R3: A valid sample whose value differs from that channel's stored value sets the channel's status bit, visible after the sampling clock edge. A sample equal to the stored value sets nothing. In both cases the stored value is replaced.
- R4: A status bit stays set until it is cleared by writing 1 to its position at its status address. Writing 0 leaves it unchanged. A change arriving in the same cycle as the clear keeps the bit set.
- R5: The summary flag is set only by a change on a channel whose enable bit is 1 in the same cycle. Enabling a channel later does not set the summary from that channel's older flag.
- R6: The interrupt output is high exactly while both the summary flag and the interrupt enable are 1. It stays high until the summary flag is cleared or the enable is written 0.
- R7: Reading any register leaves every flag and mask unchanged.
- R8: Channels 0 and 16 (the alignment and alarm positions in channel-associated framing) latch changes like any other channel.
- R9: Synchronous active-high reset clears all stored values, flags and masks, and drives the interrupt output low.
- R10: Writing 1 to the summary flag clears it, unless an enabled change arrives in the same cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Signaling sample strobe |
| smp_idx | input | 5 | Channel index of the sample |
| smp_val | input | 4 | Signaling value of the sample |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A sample or a register write presented before a rising edge takes effect at that edge. The new status, summary and mask values therefore appear on the read port, and the new level on the interrupt line, one cycle after the stimulus. Read data is combinational from the address. The bench drives every input on the falling edge, holds it across one rising edge, and compares the read port and the interrupt line on the following falling edge. By then exactly one register stage has updated. The same-cycle set-and-clear cases drive a sample and a write in the same half-period, so both land on a single edge.

// File: rtl/sig_chg_pkg.sv
package sig_chg_pkg;

    localparam int NUM_CH  = 32;
    localparam int SIG_W   = 4;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int NUM_GRP = NUM_CH / REG_W;
    localparam int IDX_W   = $clog2(NUM_CH);
    localparam int GRP_W   = $clog2(NUM_GRP);

    localparam int STAT_BASE = 0;
    localparam int MASK_BASE = NUM_GRP;
    localparam int SUM_ADDR  = 2 * NUM_GRP;
    localparam int IE_ADDR   = 2 * NUM_GRP + 1;

    typedef enum logic [2:0] {
        RK_STAT,
        RK_MASK,
        RK_SUM,
        RK_IE,
        RK_NONE
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t          kind;
        logic [GRP_W-1:0]   grp;
    } reg_dec_t;

    typedef struct packed {
        logic               valid;
        logic [IDX_W-1:0]   idx;
        logic [SIG_W-1:0]   val;
    } sig_smp_t;

    function automatic reg_dec_t reg_decode(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.grp  = a[GRP_W-1:0];
        if (int'(a) < MASK_BASE)       d.kind = RK_STAT;
        else if (int'(a) < SUM_ADDR)   d.kind = RK_MASK;
        else if (int'(a) == SUM_ADDR)  d.kind = RK_SUM;
        else if (int'(a) == IE_ADDR)   d.kind = RK_IE;
        else                           d.kind = RK_NONE;
        return d;
    endfunction

    function automatic logic [NUM_CH-1:0] grp_spread(input logic [GRP_W-1:0] g,
                                                     input logic [REG_W-1:0] d);
        logic [NUM_CH-1:0] v;
        v = '0;
        v[REG_W-1:0] = d;
        return v << (int'(g) * REG_W);
    endfunction

endpackage

// File: rtl/sig_chan_store.sv
module sig_chan_store
    import sig_chg_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int S_W  = SIG_W,
    localparam int I_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [I_W-1:0]    smp_idx,
    input  logic [S_W-1:0]    smp_val,
    output logic [N_CH-1:0]   chg_vec
);

    logic [S_W-1:0]  last_q [N_CH];
    logic [N_CH-1:0] seen_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic hit;
        assign hit = smp_valid && (int'(smp_idx) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                last_q[g] <= '0;
                seen_q[g] <= 1'b0;
            end else if (hit) begin
                last_q[g] <= smp_val;
                seen_q[g] <= 1'b1;
            end
        end

        assign chg_vec[g] = hit && seen_q[g] && (last_q[g] != smp_val);
    end

    AST_SAMPLE_STORED: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (seen_q[$past(smp_idx)] && last_q[$past(smp_idx)] == $past(smp_val))) // R2
        else $error("sample value not stored");

    AST_CHG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg_vec)) // R3
        else $error("more than one channel changed");

endmodule

// File: rtl/sig_stat_bank.sv
module sig_stat_bank
    import sig_chg_pkg::*;
#(
    parameter int N_CH = NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   set_vec,
    input  logic [N_CH-1:0]   clr_vec,
    output logic [N_CH-1:0]   stat_q
);

    for (genvar g = 0; g < N_CH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             stat_q[g] <= 1'b0;
            else if (set_vec[g]) stat_q[g] <= 1'b1;
            else if (clr_vec[g]) stat_q[g] <= 1'b0;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec))) // R4
        else $error("status bit dropped without clear");

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))) // R3
        else $error("change did not set status");

endmodule

// File: rtl/sig_sum_irq.sv
module sig_sum_irq (
    input  logic clk,
    input  logic rst,
    input  logic sum_set,
    input  logic sum_clr,
    input  logic ie_wr,
    input  logic ie_val,
    output logic summary_q,
    output logic ie_q,
    output logic irq_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            summary_q <= 1'b0;
            ie_q      <= 1'b0;
        end else begin
            if (sum_set)      summary_q <= 1'b1;
            else if (sum_clr) summary_q <= 1'b0;
            if (ie_wr)        ie_q      <= ie_val;
        end
    end

    assign irq_o = summary_q & ie_q;

    AST_SUM_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (!summary_q && !sum_set) |=> !summary_q) // R5
        else $error("summary set without enabled change");

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !sum_clr && !(ie_wr && !ie_val)) |=> irq_o) // R6
        else $error("interrupt dropped without clear");

    AST_SUM_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (sum_set && sum_clr) |=> summary_q) // R10
        else $error("clear beat same-cycle set");

endmodule

// File: rtl/sig_chg_latch.sv
module sig_chg_latch
    import sig_chg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [IDX_W-1:0]    smp_idx,
    input  logic [SIG_W-1:0]    smp_val,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq_o
);

    sig_smp_t           smp;
    reg_dec_t           dec;
    logic [NUM_CH-1:0]  chg_vec;
    logic [NUM_CH-1:0]  clr_vec;
    logic [NUM_CH-1:0]  stat_q;
    logic [NUM_CH-1:0]  en_q;
    logic               summary_q;
    logic               ie_q;
    logic               sum_set;
    logic               sum_clr;
    logic               ie_wr;

    assign smp = '{valid: smp_valid, idx: smp_idx, val: smp_val};
    assign dec = reg_decode(reg_addr);

    sig_chan_store #(.N_CH(NUM_CH), .S_W(SIG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp.valid),
        .smp_idx   (smp.idx),
        .smp_val   (smp.val),
        .chg_vec   (chg_vec)
    );

    assign clr_vec = (reg_wr && dec.kind == RK_STAT) ? grp_spread(dec.grp, reg_wdata) : '0;

    sig_stat_bank #(.N_CH(NUM_CH)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (chg_vec),
        .clr_vec (clr_vec),
        .stat_q  (stat_q)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                en_q[g*REG_W +: REG_W] <= '0;
            else if (reg_wr && dec.kind == RK_MASK && int'(dec.grp) == g)
                en_q[g*REG_W +: REG_W] <= reg_wdata;
        end
    end

    assign sum_set = |(chg_vec & en_q);
    assign sum_clr = reg_wr && dec.kind == RK_SUM && reg_wdata[0];
    assign ie_wr   = reg_wr && dec.kind == RK_IE;

    sig_sum_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .sum_set   (sum_set),
        .sum_clr   (sum_clr),
        .ie_wr     (ie_wr),
        .ie_val    (reg_wdata[0]),
        .summary_q (summary_q),
        .ie_q      (ie_q),
        .irq_o     (irq_o)
    );

    always_comb begin
        unique case (dec.kind)
            RK_STAT: reg_rdata = stat_q[int'(dec.grp)*REG_W +: REG_W];
            RK_MASK: reg_rdata = en_q[int'(dec.grp)*REG_W +: REG_W];
            RK_SUM:  reg_rdata = {{(REG_W-1){1'b0}}, summary_q};
            RK_IE:   reg_rdata = {{(REG_W-1){1'b0}}, ie_q};
            default: reg_rdata = '0;
        endcase
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && dec.kind == RK_MASK) |=> $stable(en_q)) // R7
        else $error("mask changed without write");

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && stat_q == '0)) // R9
        else $error("state not cleared by reset");

endmodule

// File: tb/sig_chg_latch_tb.sv
module sig_chg_latch_tb_top;
    import sig_chg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic [IDX_W-1:0]  smp_idx = '0;
    logic [SIG_W-1:0]  smp_val = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_chg_latch dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_idx(smp_idx),
        .smp_val(smp_val), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // op: 0 sample(a=channel, d=value), 1 write(a=addr, d=data),
    //     2 read check(a=addr, d=expected), 3 irq check(d[0]=expected)
    typedef struct packed {
        logic [1:0] op;
        logic [4:0] a;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 5'd4,  8'h01, 4'd5},  // enable ch0 (R5)
        '{2'd1, 5'd9,  8'h01, 4'd6},  // interrupt enable (R6)
        '{2'd2, 5'd9,  8'h01, 4'd1},  // R1 ie readback
        '{2'd0, 5'd0,  8'h05, 4'd2},  // first sample ch0 (R2)
        '{2'd2, 5'd0,  8'h00, 4'd2},  // R2 no flag
        '{2'd2, 5'd8,  8'h00, 4'd2},  // R2 no summary
        '{2'd0, 5'd0,  8'h05, 4'd3},  // same value
        '{2'd2, 5'd0,  8'h00, 4'd3},  // R3 equal sets nothing
        '{2'd0, 5'd0,  8'h06, 4'd3},  // differing value
        '{2'd2, 5'd0,  8'h01, 4'd3},  // R3 flag set
        '{2'd2, 5'd8,  8'h01, 4'd5},  // R5 summary set
        '{2'd3, 5'd0,  8'h01, 4'd6},  // R6 irq high
        '{2'd2, 5'd0,  8'h01, 4'd7},  // R7 reread unchanged
        '{2'd0, 5'd16, 8'h03, 4'd8},  // ch16 first
        '{2'd0, 5'd16, 8'h02, 4'd8},  // ch16 change
        '{2'd2, 5'd2,  8'h01, 4'd8},  // R8 ch16 at addr2 bit0
        '{2'd1, 5'd0,  8'h00, 4'd4},  // write 0: no effect
        '{2'd2, 5'd0,  8'h01, 4'd4},  // R4 write 0 keeps
        '{2'd1, 5'd0,  8'h01, 4'd4},  // W1C ch0
        '{2'd2, 5'd0,  8'h00, 4'd4},  // R4 cleared
        '{2'd2, 5'd2,  8'h01, 4'd4},  // R4 other group kept
        '{2'd1, 5'd8,  8'h01, 4'd6},  // clear summary
        '{2'd2, 5'd8,  8'h00, 4'd6},  // R6 summary clear
        '{2'd3, 5'd0,  8'h00, 4'd6},  // R6 irq low
        '{2'd0, 5'd16, 8'h09, 4'd5},  // change on disabled ch16
        '{2'd2, 5'd8,  8'h00, 4'd5},  // R5 no summary
        '{2'd0, 5'd31, 8'h01, 4'd1},  // ch31 first
        '{2'd0, 5'd31, 8'h00, 4'd1},  // ch31 change
        '{2'd2, 5'd3,  8'h80, 4'd1},  // R1 ch31 at addr3 bit7
        '{2'd1, 5'd7,  8'h80, 4'd5},  // enable ch31 late
        '{2'd2, 5'd7,  8'h80, 4'd1},  // R1 mask readback
        '{2'd2, 5'd8,  8'h00, 4'd5},  // R5 not retroactive
        '{2'd0, 5'd31, 8'h0F, 4'd5},  // enabled change
        '{2'd3, 5'd0,  8'h01, 4'd6}   // R6 irq high again
    };

    task automatic check(input int req, input int act, input int exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_sample(input int ch, input int val);
        @(negedge clk);
        smp_valid = 1'b1; smp_idx = IDX_W'(ch); smp_val = SIG_W'(val);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = REG_W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_chk(input int req, input int a, input int exp);
        reg_addr = ADDR_W'(a);
        #1;
        check(req, int'(reg_rdata), exp, $sformatf("read addr %0d", a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        for (int a = 0; a < 16; a++) read_chk(9, a, 0);
        check(9, int'(irq_o), 0, "irq after reset");

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_sample(int'(VEC[i].a), int'(VEC[i].d));
                2'd1: do_write(int'(VEC[i].a), int'(VEC[i].d));
                2'd2: read_chk(int'(VEC[i].req), int'(VEC[i].a), int'(VEC[i].d));
                default: check(int'(VEC[i].req), int'(irq_o), int'(VEC[i].d[0]), "irq level");
            endcase
        end

        // R6 disabling the interrupt drops the line, summary kept
        do_write(9, 0);
        check(6, int'(irq_o), 0, "irq after disable");
        read_chk(6, 8, 1);
        do_write(9, 1);
        check(6, int'(irq_o), 1, "irq after re-enable");

        // R4 change and clear in the same cycle on ch31: stays set
        @(negedge clk);
        smp_valid = 1'b1; smp_idx = 5'd31; smp_val = 4'h3;
        reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h80;
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
        read_chk(4, 3, 8'h80);

        // R10 enabled change and summary clear in the same cycle
        @(negedge clk);
        smp_valid = 1'b1; smp_idx = 5'd31; smp_val = 4'h4;
        reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h01;
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
        read_chk(10, 8, 1);
        do_write(8, 1);
        read_chk(10, 8, 0);

        // R9 reset mid-run, then R2 first sample after reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_chk(9, 3, 0);
        read_chk(9, 7, 0);
        check(9, int'(irq_o), 0, "irq after second reset");
        do_sample(31, 9);
        read_chk(2, 3, 0);
        do_sample(31, 9);
        read_chk(3, 3, 0);
        do_sample(31, 2);
        read_chk(3, 3, 8'h80);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule